// File: doc/BRIEF.md
# Circular Passing-Window Phase Selector

This block takes a pass/fail mask with one bit per sampling phase and picks one phase to use. It looks for the longest group of consecutive passing phases and treats the phase ring as circular, so a group that runs off the top phase and continues from phase 0 counts as a single group. Inside the chosen group it takes the phase about three quarters of the way along rather than the centre. This keeps the choice away from the late edge of the window, where the margin is smaller.

A caller loads a mask with a one-cycle start strobe. The block then walks the mask one phase per cycle. After a fixed latency it pulses either `valid_o`, with the chosen phase on `phase_o`, or `err_o` when no phase passed. Producing the mask and applying the chosen phase are handled outside this block.

Top module: `phase_window_sel`

## Requirements
- R1: After reset, `valid_o` and `err_o` are low and `phase_o` is 0.
- R2: Passing phases, taken in ascending order, form groups. A new group begins whenever a passing phase does not directly follow the previous passing phase.
- R3: When phase 0 and the top phase (15) both pass and the mask is not all ones, the group that ends at 15 and the group that starts at 0 are one group. It begins at the first phase of the group that ends at 15 and continues through 0.
- R4: The longest group is chosen. On a tie, the group whose first phase is lowest wins. A merged group (R3) is ranked by the first phase of its part that ends at 15.
- R5: For a chosen group of length L, let k = floor(3·L/4), reduced by one when k is not zero. The output is the phase k steps after the group's first phase, counted modulo 16.
- R6: An all-ones mask is a single group of 16 starting at phase 0 and yields phase 11.
- R7: An all-zero mask pulses `err_o` instead of `valid_o` and leaves `phase_o` unchanged.
- R8: If start is sampled at clock edge E, exactly one of `valid_o` or `err_o` is high for the one cycle that follows edge E+17. The two are never high together.
- R9: A start strobe sampled while a search is in progress (edges E+1 to E+16) is ignored. It does not change the result and produces no extra result.
- R10: `phase_o` changes only at a `valid_o` pulse and otherwise holds the last selected phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Strobe that loads `mask_i` and begins a search |
| mask_i | input | 16 | Pass/fail mask, bit n = phase n passed |
| phase_o | output | 4 | Selected phase |
| valid_o | output | 1 | One-cycle pulse, `phase_o` holds a new result |
| err_o | output | 1 | One-cycle pulse, mask had no passing phase |

## Verification
The hardest case to reach is a tie between a wrapped group and an ordinary group. In that case the ordinary group must win when its first phase is lower, even though the wrapped group's tail sits at phase 0. Random masks seldom produce it, so the stimulus includes crafted masks such as 0x8F07, where a wrapped group of four ties with phases 8 to 11. It also includes masks for every single-pass and single-fail pattern and a mid-search restart strobe. Several thousand random masks are then compared against a model that, unlike the design, searches from every group start around the ring.

// File: rtl/phsel_pkg.sv
package phsel_pkg;
    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_SCAN = 1'b1
    } scan_st_e;
endpackage

// File: rtl/phase_run_scan.sv
module phase_run_scan
    import phsel_pkg::*;
#(
    parameter  int unsigned NUM_PH = 16,
    localparam int unsigned PH_W   = $clog2(NUM_PH),
    localparam int unsigned LEN_W  = $clog2(NUM_PH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [NUM_PH-1:0] mask_i,
    output logic              fin_o,
    output logic [PH_W-1:0]   best_start_o,
    output logic [LEN_W-1:0]  best_len_o
);
    typedef struct packed {
        scan_st_e          st;
        logic [NUM_PH-1:0] mask;
        logic [PH_W-1:0]   idx;
        logic [PH_W-1:0]   cur_start;
        logic [PH_W-1:0]   best_start;
        logic [LEN_W-1:0]  cur_len;
        logic [LEN_W-1:0]  len0;
        logic [LEN_W-1:0]  best_len;
        logic              fin;
    } scan_s;

    scan_s scan_d, scan_q;

    logic             wrap;
    logic             last;
    logic             ends;
    logic [PH_W-1:0]  nxt_idx;
    logic [PH_W-1:0]  run_s;
    logic [LEN_W-1:0] run_n;
    logic [LEN_W-1:0] cand;

    always_comb begin
        wrap    = scan_q.mask[0] & scan_q.mask[NUM_PH-1] & ~(&scan_q.mask);
        last    = (scan_q.idx == PH_W'(NUM_PH - 1));
        nxt_idx = last ? '0 : scan_q.idx + 1'b1;
        run_s   = (scan_q.cur_len == '0) ? scan_q.idx : scan_q.cur_start;
        run_n   = scan_q.cur_len + 1'b1;
        ends    = last || !scan_q.mask[nxt_idx];
        if (wrap && (run_s == '0)) begin
            cand = '0;
        end else if (wrap && last) begin
            cand = run_n + scan_q.len0;
        end else begin
            cand = run_n;
        end

        scan_d     = scan_q;
        scan_d.fin = 1'b0;
        case (scan_q.st)
            SC_IDLE: begin
                if (start_i) begin
                    scan_d.st         = SC_SCAN;
                    scan_d.mask       = mask_i;
                    scan_d.idx        = '0;
                    scan_d.cur_start  = '0;
                    scan_d.cur_len    = '0;
                    scan_d.len0       = '0;
                    scan_d.best_start = '0;
                    scan_d.best_len   = '0;
                end
            end
            default: begin
                if (scan_q.mask[scan_q.idx]) begin
                    if (ends) begin
                        if (wrap && (run_s == '0)) begin
                            scan_d.len0 = run_n;
                        end
                        if (cand > scan_q.best_len) begin
                            scan_d.best_len   = cand;
                            scan_d.best_start = run_s;
                        end
                        scan_d.cur_len = '0;
                    end else begin
                        scan_d.cur_start = run_s;
                        scan_d.cur_len   = run_n;
                    end
                end
                scan_d.idx = nxt_idx;
                if (last) begin
                    scan_d.st  = SC_IDLE;
                    scan_d.fin = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scan_q <= '{st: SC_IDLE, default: '0};
        end else begin
            scan_q <= scan_d;
        end
    end

    assign fin_o        = scan_q.fin;
    assign best_start_o = scan_q.best_start;
    assign best_len_o   = scan_q.best_len;

    // R9: a strobe during a search leaves the captured mask untouched
    assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_q.st == SC_SCAN && start_i) |=> $stable(scan_q.mask));

    // R8: the last phase step is followed by the finish pulse
    assert_scan_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_q.st == SC_SCAN && last) |=> (scan_q.fin && scan_q.st == SC_IDLE));

    // R4: a chosen group cannot be longer than the number of passing phases
    assert_len_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        scan_q.fin |-> (32'(scan_q.best_len) <= $countones(scan_q.mask)));
endmodule

// File: rtl/phase_pick.sv
module phase_pick #(
    parameter  int unsigned NUM_PH = 16,
    localparam int unsigned PH_W   = $clog2(NUM_PH),
    localparam int unsigned LEN_W  = $clog2(NUM_PH + 1),
    localparam int unsigned WK     = LEN_W + 2
) (
    input  logic [PH_W-1:0]  start_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [PH_W-1:0]  phase_o
);
    logic [WK-1:0] k;
    logic [WK-1:0] sum;

    always_comb begin
        k = (WK'(len_i) * WK'(3)) >> 2;
        if (k != '0) begin
            k = k - 1'b1;
        end
        sum = WK'(start_i) + k;
        if (sum >= WK'(NUM_PH)) begin
            sum = sum - WK'(NUM_PH);
        end
        phase_o = sum[PH_W-1:0];
    end

    // R5: the offset always lands inside a group of the given length
    always_comb begin
        assert_offset_in_run_R5: assert (len_i == '0 || k < WK'(len_i));
    end
endmodule

// File: rtl/phase_window_sel.sv
module phase_window_sel #(
    parameter  int unsigned NUM_PH = 16,
    localparam int unsigned PH_W   = $clog2(NUM_PH),
    localparam int unsigned LEN_W  = $clog2(NUM_PH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [NUM_PH-1:0] mask_i,
    output logic [PH_W-1:0]   phase_o,
    output logic              valid_o,
    output logic              err_o
);
    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            valid;
        logic            err;
    } res_s;

    res_s res_d, res_q;

    logic             fin;
    logic [PH_W-1:0]  best_start;
    logic [LEN_W-1:0] best_len;
    logic [PH_W-1:0]  pick;

    phase_run_scan #(.NUM_PH(NUM_PH)) i_scan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .mask_i       (mask_i),
        .fin_o        (fin),
        .best_start_o (best_start),
        .best_len_o   (best_len)
    );

    phase_pick #(.NUM_PH(NUM_PH)) i_pick (
        .start_i (best_start),
        .len_i   (best_len),
        .phase_o (pick)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = fin && (best_len != '0);
        res_d.err   = fin && (best_len == '0);
        if (res_d.valid) begin
            res_d.phase = pick;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign phase_o = res_q.phase;
    assign valid_o = res_q.valid;
    assign err_o   = res_q.err;

    assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && err_o));

    assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o || err_o) |=> !(valid_o || err_o));

    assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fin |=> $stable(phase_o));

    assert_err_keeps_phase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fin && best_len == '0) |=> (err_o && $stable(phase_o)));
endmodule

// File: tb/test_phase_window_sel.sv
module test_phase_window_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mask = '0;
    logic [3:0]  phase;
    logic        valid;
    logic        err;

    int unsigned compared   = 0;
    int unsigned mismatched = 0;
    longint      cyc        = 0;
    logic [3:0]  last_good  = 4'd0;
    bit          done       = 1'b0;

    typedef struct {
        logic [15:0] m;
        int          ph;
        bit          er;
        longint      due;
        string       req;
    } item_t;

    item_t exp_q[$];

    phase_window_sel i_phase_window_sel (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .mask_i  (mask),
        .phase_o (phase),
        .valid_o (valid),
        .err_o   (err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Independent model: scan from every group start around the ring.
    task automatic ref_model(input logic [15:0] m, output int ph, output bit er);
        int bs, bl, k;
        bs = 0; bl = 0;
        er = (m == 16'h0);
        if (&m) begin
            bs = 0; bl = 16;
        end else begin
            for (int s = 0; s < 16; s++) begin
                if (m[s] && !m[(s + 15) % 16]) begin
                    int l;
                    l = 0;
                    while (l < 16 && m[(s + l) % 16]) l++;
                    if (l > bl) begin bl = l; bs = s; end
                end
            end
        end
        k = (3 * bl) / 4;
        if (k > 0) k--;
        ph = (bs + k) % 16;
    endtask

    task automatic run(input logic [15:0] m, input string req);
        item_t it;
        @(negedge clk);
        ref_model(m, it.ph, it.er);
        it.m = m; it.due = cyc + 18; it.req = req;
        exp_q.push_back(it);
        start = 1'b1; mask = m;
        @(negedge clk);
        start = 1'b0; mask = $urandom();
        repeat (15) @(negedge clk);
    endtask

    // Monitor: pop and compare on each result pulse
    always @(negedge clk) begin
        if (rst_n && (valid || err)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result", 1, 0);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(cyc == it.due, "R8 latency", cyc, it.due);
                check(err == it.er, {it.req, " error flag"}, err, it.er);
                if (it.er) begin
                    check(phase == last_good, "R7 phase kept on error", phase, last_good);
                end else begin
                    check(phase == 4'(it.ph), {it.req, " phase"}, phase, it.ph);
                    last_good = phase;
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!valid && !err, "R1 flags after reset", {valid, err}, 0);
        check(phase == 4'd0, "R1 phase after reset", phase, 0);
        rst_n = 1'b1;

        run(16'hFFFF, "R6 all pass");
        run(16'h0000, "R7 empty");
        run(16'h0001, "R5 single phase 0");
        run(16'h8000, "R5 single phase 15");
        run(16'h8001, "R3 wrap pair");
        run(16'hC003, "R3 wrap four");
        run(16'h0F0F, "R4 tie earliest");
        run(16'h8F07, "R4 tie wrapped vs plain");
        run(16'hF00F, "R3 wrap eight");
        run(16'h7FFE, "R5 long inner run");
        run(16'hFFFE, "R2 no wrap without phase 0");
        run(16'h5555, "R2 isolated phases");
        run(16'h00F1, "R4 longer later group");

        // R9: a strobe during the search is ignored
        begin
            item_t it;
            @(negedge clk);
            ref_model(16'h0F0F, it.ph, it.er);
            it.m = 16'h0F0F; it.due = cyc + 18; it.req = "R9 strobe ignored";
            exp_q.push_back(it);
            start = 1'b1; mask = 16'h0F0F;
            @(negedge clk); start = 1'b0;
            repeat (5) @(negedge clk);
            start = 1'b1; mask = 16'hFFFF;
            @(negedge clk); start = 1'b0;
            repeat (9) @(negedge clk);
            start = 1'b1; mask = 16'h0001;   // sampled at E+16: still busy
            @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        end

        // R10: phase holds between results
        repeat (4) @(negedge clk);
        check(phase == last_good, "R10 hold", phase, last_good);

        for (int b = 0; b < 16; b++) run(16'(1) << b, "R5 one pass");
        for (int b = 0; b < 16; b++) run(~(16'(1) << b), "R3 one fail");
        for (int n = 0; n < 7000; n++) run(16'($urandom()), "R2 random");

        repeat (25) @(negedge clk);
        check(exp_q.size() == 0, "R8 all results seen", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule